// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave side of a three-wire configuration port. An external master selects it with an active-low chip select, supplies a serial clock and shares one data line with it. Each transfer carries sixteen bits. The first bit says whether the transfer is a read or a write. Seven address bits follow, and then one data byte. On a write the byte goes into a small bank of 8-bit control registers. On a read the port takes over the shared line halfway through the transfer and sends the register's contents back.

The pad inputs are asynchronous to the system clock `clk`. A two-stage synchronizer brings them into the clock domain, and the serial clock's edges are detected in that domain, so the serial clock must run well below `clk`. The shared pin is modelled as a separate data input, data output and output enable, and the pad cell joins them. The control registers hold the lower `NUM_REGS` addresses of a 128-entry space. All register contents appear on a flat output bus for the surrounding logic. Each completed write is also reported through an address/data/strobe group.

Top module: `tw_regport`

## Requirements
- R1: Data bits are taken only on rising serial-clock edges seen while `cs_n` is low. While `cs_n` is high, any toggling of `sclk` and `sdi` leaves every output unchanged, including `bank_wr`, `sdo_oe` and `ctrl_regs`.
- R2: The sixteen bits are taken MSB first in this order: the operation flag (0 = write, 1 = read), address bit 6 down to address bit 0, then data bit 7 down to data bit 0.
- R3: A write frame raises `bank_wr` for exactly one `clk` cycle once the 16th bit has arrived. During that cycle `bank_addr` and `bank_wdata` show the frame's address and byte. Rising edges after the 16th bit are ignored, so a frame gives at most one strobe.
- R4: If `cs_n` rises before the 16th bit of a write frame, there is no strobe and no register changes.
- R5: On a read frame, `sdo_oe` stays low through the 8th rising serial-clock edge. It rises after the falling edge that follows that rising edge, with `sdo` already showing data bit 7.
- R6: On a read frame, each later falling edge moves `sdo` to the next lower data bit. The eight bits the master captures on rising edges 9 to 16 equal the addressed register's contents, MSB first.
- R7: When `cs_n` goes high, `sdo_oe` drops and the bit count restarts. A read cut short and followed by a full frame returns correct data.
- R8: Addresses at or above `NUM_REGS` read back as 0x00. Writes to them leave `ctrl_regs` unchanged.
- R9: After reset all registers are 0x00, `sdo_oe` is low and `bank_wr` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select from the master, active low |
| sclk | input | 1 | Serial clock from the master |
| sdi | input | 1 | Data from the shared pin |
| sdo | output | 1 | Data toward the shared pin |
| sdo_oe | output | 1 | Drive enable for the shared pin |
| bank_addr | output | 7 | Address of the current or last frame |
| bank_wdata | output | 8 | Byte of the last write frame |
| bank_wr | output | 1 | One-cycle strobe for a completed write |
| ctrl_regs | output | NUM_REGS*8 | Register contents, register i in bits [8i+7:8i] |

## Verification
A change on a pad acts on the registered outputs at the third rising `clk` edge after it is driven. Two edges go to the synchronizer and one to the engine register. A completed write appears in `ctrl_regs` one edge after the strobe. The bench's reference model reads its pad history two samples late and applies the bank update one step after the strobe, so its outputs line up with the design's cycle for cycle. The model is compared with the design on every falling `clk` edge. The directed checks wait at least four `clk` cycles after each pad change they depend on. The early-enable check samples the last cycle before the falling serial edge, when `sdo_oe` must still be low.

// File: rtl/tw_regport_pkg.sv
package tw_regport_pkg;

    localparam int unsigned DATA_W     = 8;
    localparam int unsigned ADDR_W     = 7;
    localparam int unsigned CTRL_BITS  = 1 + ADDR_W;
    localparam int unsigned FRAME_BITS = CTRL_BITS + DATA_W;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS + 1);

    localparam logic [CNT_W-1:0] CNT_LAST_CTRL = CNT_W'(CTRL_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_CTRL_DONE = CNT_W'(CTRL_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST_BIT  = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] CNT_FULL      = CNT_W'(FRAME_BITS);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] shreg;
        logic              is_read;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] obuf;
        logic              oe;
        logic              sdo;
        logic              wr;
        logic [DATA_W-1:0] wdata;
        logic              sclk_prev;
    } eng_state_t;

endpackage

// File: rtl/tw_regport_sync.sv
module tw_regport_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] chain_d;
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < int'(STAGES); i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/tw_regport_bank.sv
module tw_regport_bank
    import tw_regport_pkg::*;
#(
    parameter int unsigned NUM_REGS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [ADDR_W-1:0]          wr_addr,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [ADDR_W-1:0]          rd_addr,
    output logic [DATA_W-1:0]          rd_data,
    output logic [NUM_REGS*DATA_W-1:0] regs_flat
);

    localparam int unsigned IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;
    logic wr_hit;
    logic rd_hit;

    assign wr_hit = wr && ({1'b0, wr_addr} < LIMIT);
    assign rd_hit = {1'b0, rd_addr} < LIMIT;

    for (genvar g = 0; g < int'(NUM_REGS); g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_hit && (wr_addr[IDX_W-1:0] == IDX_W'(g))) begin
                regs_d[g] = wr_data;
            end
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data = rd_hit ? regs_q[rd_addr[IDX_W-1:0]] : '0;

    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !rd_hit && (wr_addr == rd_addr)) |=> $stable(regs_q)); // R8
    AST_NO_WRITE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(regs_q)); // R4

endmodule

// File: rtl/tw_regport_engine.sv
module tw_regport_engine
    import tw_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              sclk_lvl,
    input  logic              sdi_lvl,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              bank_wr,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_wdata
);

    eng_state_t st_d;
    eng_state_t st_q;
    logic sclk_rise;
    logic sclk_fall;
    logic [DATA_W-1:0] byte_in;
    logic in_data_phase;

    assign sclk_rise     = sclk_lvl && !st_q.sclk_prev;
    assign sclk_fall     = !sclk_lvl && st_q.sclk_prev;
    assign byte_in       = {st_q.shreg[DATA_W-2:0], sdi_lvl};
    assign in_data_phase = (st_q.cnt >= CNT_CTRL_DONE) && (st_q.cnt < CNT_FULL);

    always_comb begin
        st_d           = st_q;
        st_d.wr        = 1'b0;
        st_d.sclk_prev = sclk_lvl;
        if (!cs_low) begin
            st_d.cnt     = '0;
            st_d.oe      = 1'b0;
            st_d.sdo     = 1'b0;
            st_d.is_read = 1'b0;
        end else begin
            if (sclk_rise && (st_q.cnt != CNT_FULL)) begin
                st_d.shreg = byte_in;
                st_d.cnt   = st_q.cnt + 1'b1;
                if (st_q.cnt == CNT_LAST_CTRL) begin
                    st_d.is_read = byte_in[DATA_W-1];
                    st_d.addr    = byte_in[ADDR_W-1:0];
                end
                if ((st_q.cnt == CNT_LAST_BIT) && !st_q.is_read) begin
                    st_d.wr    = 1'b1;
                    st_d.wdata = byte_in;
                end
            end
            if (sclk_fall && st_q.is_read && in_data_phase) begin
                if (st_q.cnt == CNT_CTRL_DONE) begin
                    st_d.oe   = 1'b1;
                    st_d.sdo  = rd_data[DATA_W-1];
                    st_d.obuf = {rd_data[DATA_W-2:0], 1'b0};
                end else begin
                    st_d.sdo  = st_q.obuf[DATA_W-1];
                    st_d.obuf = {st_q.obuf[DATA_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo        = st_q.sdo;
    assign sdo_oe     = st_q.oe;
    assign bank_wr    = st_q.wr;
    assign bank_addr  = st_q.addr;
    assign bank_wdata = st_q.wdata;

    AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> (st_q.cnt == '0)); // R1
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_FULL); // R2
    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |=> !bank_wr); // R3
    AST_STROBE_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        bank_wr |-> ((st_q.cnt == CNT_FULL) && !st_q.is_read)); // R3
    AST_OE_ONLY_READ_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_oe |-> (st_q.is_read && (st_q.cnt >= CNT_CTRL_DONE))); // R5
    AST_CS_HIGH_DROPS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> !sdo_oe); // R7

endmodule

// File: rtl/tw_regport.sv
module tw_regport
    import tw_regport_pkg::*;
#(
    parameter int unsigned NUM_REGS    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cs_n,
    input  logic                       sclk,
    input  logic                       sdi,
    output logic                       sdo,
    output logic                       sdo_oe,
    output logic [ADDR_W-1:0]          bank_addr,
    output logic [DATA_W-1:0]          bank_wdata,
    output logic                       bank_wr,
    output logic [NUM_REGS*DATA_W-1:0] ctrl_regs
);

    logic [2:0] pads_raw;
    logic [2:0] pads_sync;
    logic [DATA_W-1:0] rd_data;

    assign pads_raw = {cs_n, sclk, sdi};

    tw_regport_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pads_raw),
        .dout  (pads_sync)
    );

    tw_regport_engine u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_low     (!pads_sync[2]),
        .sclk_lvl   (pads_sync[1]),
        .sdi_lvl    (pads_sync[0]),
        .rd_data    (rd_data),
        .sdo        (sdo),
        .sdo_oe     (sdo_oe),
        .bank_wr    (bank_wr),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata)
    );

    tw_regport_bank #(
        .NUM_REGS (NUM_REGS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bank_wr),
        .wr_addr   (bank_addr),
        .wr_data   (bank_wdata),
        .rd_addr   (bank_addr),
        .rd_data   (rd_data),
        .regs_flat (ctrl_regs)
    );

endmodule

// File: tb/sim_tw_regport.sv
module sim_tw_regport;

    localparam int NREG = 8;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_oe;
    logic [6:0] bank_addr;
    logic [7:0] bank_wdata;
    logic bank_wr;
    logic [NREG*8-1:0] ctrl_regs;

    int total = 0;
    int failed = 0;
    int strobes = 0;
    bit done = 0;
    int exp_regs [NREG];

    always #2 clk = ~clk;

    tw_regport #(.NUM_REGS(NREG)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .sdo(sdo), .sdo_oe(sdo_oe), .bank_addr(bank_addr),
        .bank_wdata(bank_wdata), .bank_wr(bank_wr), .ctrl_regs(ctrl_regs)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Reference model: pad samples are used two clk samples late, outputs registered.
    bit h_cs_a = 1, h_cs_b = 1, h_sclk_a = 0, h_sclk_b = 0, h_sdi_a = 0, h_sdi_b = 0;
    bit m_prev = 0, m_read = 0, m_oe = 0, m_sdo = 0, m_wr = 0;
    int m_cnt = 0, m_shift = 0, m_addr = 0, m_out = 0, m_wdata = 0;
    int m_regs [NREG];

    always @(posedge clk) begin
        if (!rst_n) begin
            h_cs_a = 1; h_cs_b = 1; h_sclk_a = 0; h_sclk_b = 0; h_sdi_a = 0; h_sdi_b = 0;
            m_prev = 0; m_read = 0; m_oe = 0; m_sdo = 0; m_wr = 0;
            m_cnt = 0; m_shift = 0; m_addr = 0; m_out = 0; m_wdata = 0;
            foreach (m_regs[i]) m_regs[i] = 0;
        end else begin
            bit cur_cs, cur_sclk, cur_sdi, n_read, n_oe, n_sdo, n_wr;
            int n_cnt, n_shift, n_addr, n_out, n_wdata, rdv;
            cur_cs = h_cs_b; cur_sclk = h_sclk_b; cur_sdi = h_sdi_b;
            n_read = m_read; n_oe = m_oe; n_sdo = m_sdo; n_wr = 0;
            n_cnt = m_cnt; n_shift = m_shift; n_addr = m_addr; n_out = m_out; n_wdata = m_wdata;
            if (cur_cs) begin
                n_cnt = 0; n_oe = 0; n_sdo = 0; n_read = 0;
            end else begin
                if (cur_sclk && !m_prev && m_cnt < 16) begin
                    n_shift = ((m_shift << 1) | int'(cur_sdi)) & 8'hFF;
                    n_cnt = m_cnt + 1;
                    if (n_cnt == 8) begin
                        n_read = n_shift[7];
                        n_addr = n_shift & 8'h7F;
                    end
                    if (n_cnt == 16 && !m_read) begin
                        n_wr = 1; n_wdata = n_shift;
                    end
                end
                if (!cur_sclk && m_prev && m_read && m_cnt >= 8 && m_cnt < 16) begin
                    if (m_cnt == 8) begin
                        rdv = (m_addr < NREG) ? m_regs[m_addr] : 0;
                        n_oe = 1;
                        n_out = rdv;
                    end
                    n_sdo = n_out[7];
                    n_out = (n_out << 1) & 8'hFF;
                end
            end
            if (m_wr && m_addr < NREG) m_regs[m_addr] = m_wdata;
            m_prev = cur_sclk;
            m_read = n_read; m_oe = n_oe; m_sdo = n_sdo; m_wr = n_wr;
            m_cnt = n_cnt; m_shift = n_shift; m_addr = n_addr; m_out = n_out; m_wdata = n_wdata;
            h_cs_b = h_cs_a; h_sclk_b = h_sclk_a; h_sdi_b = h_sdi_a;
            h_cs_a = cs_n; h_sclk_a = sclk; h_sdi_a = sdi;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [NREG*8-1:0] flat;
            for (int i = 0; i < NREG; i++) flat[i*8 +: 8] = m_regs[i][7:0];
            check("R5", "model sdo_oe", 64'(sdo_oe), 64'(m_oe));
            if (m_oe) check("R6", "model sdo", 64'(sdo), 64'(m_sdo));
            check("R3", "model bank_wr", 64'(bank_wr), 64'(m_wr));
            if (m_wr) begin
                check("R2", "model bank_addr", 64'(bank_addr), 64'(m_addr));
                check("R2", "model bank_wdata", 64'(bank_wdata), 64'(m_wdata));
            end
            check("R3", "model ctrl_regs", 64'(ctrl_regs), 64'(flat));
            if (bank_wr) strobes++;
        end
    end

    task automatic frame(input bit rw, input int addr, input int data, input int nbits,
                         input int exp_rd, output int rd);
        logic [15:0] bits;
        bits = {rw, addr[6:0], data[7:0]};
        rd = 0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            if (i < 16) sdi = (rw && i >= 8) ? 1'b0 : bits[15-i];
            else sdi = i[0];
            for (int j = 0; j < HALF; j++) begin
                @(negedge clk);
                if (rw && i == 8 && j == 3) begin
                    check("R5", "oe after 8th fall", 64'(sdo_oe), 64'd1);
                    check("R5", "D7 on first driven bit", 64'(sdo), 64'(exp_rd[7]));
                end
            end
            if (i >= 8 && i < 16) rd = (rd << 1) | int'(sdo_oe & sdo);
            sclk = 1'b1;
            for (int j = 0; j < HALF; j++) begin
                @(negedge clk);
                if (rw && i == 7 && j == HALF - 1)
                    check("R5", "oe low before 8th fall", 64'(sdo_oe), 64'd0);
            end
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        sdi = 1'b0;
        repeat (4) @(negedge clk);
        check("R7", "oe low after cs high", 64'(sdo_oe), 64'd0);
        repeat (2 * HALF) @(negedge clk);
        if (!rw && nbits >= 16 && addr < NREG) exp_regs[addr] = data & 8'hFF;
    endtask

    task automatic rd_chk(input string req, input int addr);
        int expv, got;
        expv = (addr < NREG) ? exp_regs[addr] : 0;
        frame(1'b1, addr, 0, 16, expv, got);
        check(req, $sformatf("read addr %0d", addr), 64'(got), 64'(expv));
    endtask

    function automatic logic [NREG*8-1:0] exp_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = exp_regs[i][7:0];
        return f;
    endfunction

    initial begin
        int dummy, s0;
        foreach (exp_regs[i]) exp_regs[i] = 0;
        repeat (5) @(negedge clk);
        check("R9", "oe in reset", 64'(sdo_oe), 64'd0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9", "regs after reset", 64'(ctrl_regs), 64'd0);
        check("R9", "strobe after reset", 64'(bank_wr), 64'd0);
        check("R9", "oe after reset", 64'(sdo_oe), 64'd0);

        s0 = strobes;
        frame(1'b0, 3, 8'hA5, 16, 0, dummy);
        check("R3", "one strobe per write", 64'(strobes - s0), 64'd1);
        check("R2", "reg 3 written", 64'(ctrl_regs), 64'(exp_flat()));
        frame(1'b0, 0, 8'h3C, 16, 0, dummy);
        frame(1'b0, 7, 8'h81, 16, 0, dummy);
        rd_chk("R6", 3);
        rd_chk("R6", 0);
        rd_chk("R6", 7);
        rd_chk("R6", 5);

        frame(1'b0, 8'h40, 8'hFF, 16, 0, dummy);
        frame(1'b0, NREG, 8'h77, 16, 0, dummy);
        check("R8", "out-of-range writes ignored", 64'(ctrl_regs), 64'(exp_flat()));
        rd_chk("R8", 8'h40);
        rd_chk("R8", NREG);
        rd_chk("R8", 127);

        s0 = strobes;
        frame(1'b0, 3, 8'h11, 12, 0, dummy);
        frame(1'b0, 3, 8'h22, 15, 0, dummy);
        check("R4", "aborted writes no strobe", 64'(strobes - s0), 64'd0);
        check("R4", "aborted writes no change", 64'(ctrl_regs), 64'(exp_flat()));

        s0 = strobes;
        for (int k = 0; k < 24; k++) begin
            sdi = k[1];
            sclk = k[0];
            repeat (HALF) @(negedge clk);
        end
        sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        check("R1", "cs high no strobe", 64'(strobes - s0), 64'd0);
        check("R1", "cs high regs unchanged", 64'(ctrl_regs), 64'(exp_flat()));
        check("R1", "cs high oe low", 64'(sdo_oe), 64'd0);

        s0 = strobes;
        frame(1'b0, 2, 8'h5A, 21, 0, dummy);
        check("R3", "extra bits one strobe", 64'(strobes - s0), 64'd1);
        check("R3", "extra bits value", 64'(ctrl_regs), 64'(exp_flat()));

        frame(1'b1, 2, 0, 11, exp_regs[2], dummy);
        rd_chk("R7", 2);
        frame(1'b0, 6, 8'hC3, 16, 0, dummy);
        rd_chk("R2", 6);

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

endmodule